// File: doc/BRIEF.md
# Via Test and Repair Cell Array

This block wraps a row of vertical die-to-die vias, one cell per via, and gives each via three lives. During probe, the cell presents the via level and a reference to an external comparator and captures the verdict on a scan-clock edge. During scan, the cells form a shift chain through the same capture stage, so verdicts can be unloaded and configuration bits loaded. During operation, each cell either passes the raw via level straight to the core logic or routes the comparator output through a transparent capture stage, which restores a weak signal.

The per-via choice between recovery and bypass is held in the cell's configuration bit. That bit is also the scan flop state. Recovery mode freezes it, so normal traffic can never overwrite it. All signals are plain levels sampled on `clk`; `scan_clk` is a slow, level-sampled control. No handshake applies: every lane carries a continuous level, not a stream, so there is no back-pressure.

Top module: `via_repair_array`

## Requirements
- R1: The capture data input of lane i (`sense_a[i]`) is the chain input when `scan_sel`=1 and `via_lvl[i]` when `scan_sel`=0. The chain input of lane 0 is `scan_in`; the chain input of lane i>0 is the configuration bit of lane i-1.
- R2: `sense_b[i]` equals `vref_lvl` while `test_en`=1 and equals the complement of `sense_a[i]` while `test_en`=0.
- R3: While `test_en`=1 or `scan_sel`=1, every configuration bit loads the comparator result `cmp_res[i]` at the first `clk` edge that samples `scan_clk` high after a low sample, and holds otherwise. `test_en` and `scan_sel` may change only while `scan_clk` is low.
- R4: In recovery mode (`test_en`=0 and `scan_sel`=0), the capture stage is transparent and no `scan_clk` activity changes any configuration bit.
- R5: With `op_mode`=0 (logic test), `core_data[i]` is the configuration bit of lane i, and `scan_out` is always the bit of the last lane.
- R6: With `op_mode`=1 in recovery mode, a lane whose configuration bit is 1 drives `core_data[i]` from `cmp_res[i]` in the same cycle.
- R7: With `op_mode`=1, a lane whose configuration bit is 0 drives `core_data[i]` from `via_lvl[i]` in the same cycle.
- R8: Reset (`rst_n`=0) clears every configuration bit to 0 (bypass), so `scan_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| test_en | input | 1 | Probe select: reference on the second comparator input |
| scan_sel | input | 1 | Capture data from the chain instead of the via |
| op_mode | input | 1 | 1 = operating, 0 = logic test |
| scan_clk | input | 1 | Scan/probe capture clock, level-sampled |
| scan_in | input | 1 | Serial chain input |
| vref_lvl | input | 1 | Reference level for probing |
| via_lvl | input | NUM_VIAS | Received via levels |
| cmp_res | input | NUM_VIAS | Comparator results per lane |
| sense_a | output | NUM_VIAS | First comparator input per lane |
| sense_b | output | NUM_VIAS | Second comparator input per lane |
| scan_out | output | 1 | Serial chain output |
| core_data | output | NUM_VIAS | Level delivered to the core logic |

## Verification
A corrupted configuration bit appears as a wrong lane source in operation: the lane shows the via where the comparator was expected, or the reverse. The bench drives the comparator opposite to the via on purpose, so such an error is visible in the same cycle. A wrong capture stage shows up one scan pulse later on `scan_out` and in logic-test mode. A missing freeze in recovery mode shows up in the first cycle after a scan-clock toggle, when the core output switches source.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  typedef enum logic [1:0] {
    MODE_RECOVER = 2'd0,
    MODE_SCAN    = 2'd1,
    MODE_PROBE   = 2'd2
  } cell_mode_e;

  function automatic cell_mode_e decode_mode(input logic test_en, input logic scan_sel);
    if (test_en)       return MODE_PROBE;
    else if (scan_sel) return MODE_SCAN;
    else               return MODE_RECOVER;
  endfunction
endpackage

// File: rtl/vrc_front.sv
module vrc_front (
  input  logic test_en,
  input  logic scan_sel,
  input  logic chain_d,
  input  logic via,
  input  logic vref,
  output logic pos,
  output logic neg
);
  always_comb begin
    pos = scan_sel ? chain_d : via;
    neg = test_en ? vref : ~pos;
  end
endmodule

// File: rtl/vrc_stage.sv
module vrc_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_en,
  input  logic cap_go,
  input  logic cmp,
  output logic sa_q,
  output logic cfg
);
  logic sa_hold;

  assign sa_q = latch_en ? cmp : sa_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_hold <= 1'b0;
      cfg     <= 1'b0;
    end else begin
      sa_hold <= sa_q;
      if (cap_go) cfg <= sa_q;
    end
  end
endmodule

// File: rtl/vrc_outsel.sv
module vrc_outsel (
  input  logic op_mode,
  input  logic cfg,
  input  logic restored,
  input  logic via,
  output logic dout
);
  always_comb begin
    if (!op_mode)  dout = cfg;
    else if (cfg)  dout = restored;
    else           dout = via;
  end
endmodule

// File: rtl/via_repair_array.sv
module via_repair_array #(
  parameter int NUM_VIAS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                test_en,
  input  logic                scan_sel,
  input  logic                op_mode,
  input  logic                scan_clk,
  input  logic                scan_in,
  input  logic                vref_lvl,
  input  logic [NUM_VIAS-1:0] via_lvl,
  input  logic [NUM_VIAS-1:0] cmp_res,
  output logic [NUM_VIAS-1:0] sense_a,
  output logic [NUM_VIAS-1:0] sense_b,
  output logic                scan_out,
  output logic [NUM_VIAS-1:0] core_data
);
  import vrc_pkg::*;
  localparam int LAST = NUM_VIAS - 1;

  cell_mode_e          mode;
  logic                sclk_d;
  logic                scan_rise;
  logic                hold_open;
  logic                latch_en;
  logic                cap_go;
  logic [NUM_VIAS-1:0] cfg_q;
  logic [NUM_VIAS-1:0] sa_q;
  logic [NUM_VIAS:0]   chain;

  assign mode      = decode_mode(test_en, scan_sel);
  assign hold_open = (mode == MODE_RECOVER);
  assign latch_en  = hold_open | scan_clk;
  assign scan_rise = scan_clk & ~sclk_d;
  assign cap_go    = scan_rise & ~hold_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= scan_clk;
  end

  assign chain[0] = scan_in;

  generate
    for (genvar i = 0; i < NUM_VIAS; i++) begin : g_lane
      vrc_front u_front (
        .test_en (test_en),
        .scan_sel(scan_sel),
        .chain_d (chain[i]),
        .via     (via_lvl[i]),
        .vref    (vref_lvl),
        .pos     (sense_a[i]),
        .neg     (sense_b[i])
      );
      vrc_stage u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .latch_en(latch_en),
        .cap_go  (cap_go),
        .cmp     (cmp_res[i]),
        .sa_q    (sa_q[i]),
        .cfg     (cfg_q[i])
      );
      vrc_outsel u_out (
        .op_mode (op_mode),
        .cfg     (cfg_q[i]),
        .restored(sa_q[i]),
        .via     (via_lvl[i]),
        .dout    (core_data[i])
      );
      assign chain[i+1] = cfg_q[i];
    end
  endgenerate

  assign scan_out = chain[LAST+1];
endmodule

// File: rtl/via_repair_chk.sv
module via_repair_chk #(
  parameter int NUM_VIAS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                test_en,
  input logic                scan_sel,
  input logic                op_mode,
  input logic                scan_clk,
  input logic [NUM_VIAS-1:0] via_lvl,
  input logic [NUM_VIAS-1:0] cmp_res,
  input logic [NUM_VIAS-1:0] core_data,
  input logic                scan_out,
  input logic [NUM_VIAS-1:0] cfg_q
);
  logic rec;
  assign rec = !test_en && !scan_sel;

  AST_MODE_CHANGE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(test_en) || $changed(scan_sel)) |-> !scan_clk); // R3
  AST_HOLD_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_clk && !$past(scan_clk)) |=> $stable(cfg_q)); // R3
  AST_RECOVERY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    rec |=> $stable(cfg_q)); // R4
  AST_LOGIC_TEST_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    !op_mode |-> (core_data == cfg_q) && (scan_out == cfg_q[NUM_VIAS-1])); // R5
  AST_REPAIRED_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode && rec) |-> ((core_data & cfg_q) == (cmp_res & cfg_q))); // R6
  AST_BYPASS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    op_mode |-> ((core_data & ~cfg_q) == (via_lvl & ~cfg_q))); // R7
endmodule

bind via_repair_array via_repair_chk #(.NUM_VIAS(NUM_VIAS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .test_en  (test_en),
  .scan_sel (scan_sel),
  .op_mode  (op_mode),
  .scan_clk (scan_clk),
  .via_lvl  (via_lvl),
  .cmp_res  (cmp_res),
  .core_data(core_data),
  .scan_out (scan_out),
  .cfg_q    (cfg_q)
);

// File: tb/tb_via_repair_array.sv
`timescale 1ns/1ps
module tb_via_repair_array;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_en = 1'b0, scan_sel = 1'b0, op_mode = 1'b0, scan_clk = 1'b0;
  logic scan_in = 1'b0, vref_lvl = 1'b0;
  logic [N-1:0] via_lvl = '0;
  logic [N-1:0] cmp_res;
  logic [N-1:0] sense_a, sense_b, core_data;
  logic scan_out;
  logic cmp_force = 1'b0;
  logic [N-1:0] cmp_force_val = '0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  // comparator model: pos above neg
  assign cmp_res = cmp_force ? cmp_force_val : (sense_a & ~sense_b);

  via_repair_array #(.NUM_VIAS(N)) dut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .scan_sel(scan_sel),
    .op_mode(op_mode), .scan_clk(scan_clk), .scan_in(scan_in),
    .vref_lvl(vref_lvl), .via_lvl(via_lvl), .cmp_res(cmp_res),
    .sense_a(sense_a), .sense_b(sense_b), .scan_out(scan_out),
    .core_data(core_data)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) scan_clk = 1'b1;
    @(negedge clk) scan_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_cfg(input logic [N-1:0] p);
    @(negedge clk) begin test_en = 1'b0; scan_sel = 1'b1; end
    for (int k = N - 1; k >= 0; k--) begin
      scan_in = p[k];
      pulse();
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8 scan_out", {3'b0, scan_out}, '0);
    op_mode = 1'b1; via_lvl = 4'b1011; #1;
    chk("R8 bypass after reset", core_data, 4'b1011);
    op_mode = 1'b0; #1;
    chk("R8 cfg zero", core_data, '0);
  endtask

  task automatic t_select();
    @(negedge clk) begin test_en = 1'b0; scan_sel = 1'b0; via_lvl = 4'b0110; end
    #1;
    chk("R1 via path", sense_a, 4'b0110);
    chk("R2 complement", sense_b, 4'b1001);
    @(negedge clk) begin test_en = 1'b1; vref_lvl = 1'b1; end
    #1;
    chk("R2 reference hi", sense_b, 4'b1111);
    vref_lvl = 1'b0; #1;
    chk("R2 reference lo", sense_b, 4'b0000);
    @(negedge clk) begin test_en = 1'b0; scan_sel = 1'b1; scan_in = 1'b1; end
    #1;
    chk("R1 chain path", sense_a, 4'b0001);
  endtask

  task automatic t_shift();
    logic [N-1:0] p = 4'b1101;
    op_mode = 1'b0;
    load_cfg(p);
    chk("R5 logic test view", core_data, p);
    chk("R3 shift load", core_data, p);
    for (int k = N - 1; k >= 0; k--) begin
      chk("R5 scan_out", {3'b0, scan_out}, {3'b0, p[k]});
      scan_in = 1'b0;
      pulse();
    end
    chk("R3 chain flushed", core_data, '0);
  endtask

  task automatic t_probe();
    @(negedge clk) begin scan_sel = 1'b0; test_en = 1'b1; vref_lvl = 1'b0; via_lvl = 4'b1010; end
    @(negedge clk) scan_clk = 1'b1;
    chk("R3 no capture before edge", core_data, '0);
    @(negedge clk) scan_clk = 1'b0;
    chk("R3 probe capture", core_data, 4'b1010);
    @(negedge clk) vref_lvl = 1'b1;
    pulse();
    chk("R3 probe high ref", core_data, 4'b0000);
  endtask

  task automatic t_recover();
    load_cfg(4'b0101);
    @(negedge clk) begin scan_sel = 1'b0; test_en = 1'b0; op_mode = 1'b1; end
    cmp_force = 1'b1;
    via_lvl = 4'b0011; cmp_force_val = 4'b1100; #1;
    chk("R6 R7 mixed lanes", core_data, 4'b0110);
    via_lvl = 4'b1100; cmp_force_val = 4'b0011; #1;
    chk("R6 R7 mixed lanes 2", core_data, 4'b1001);
  endtask

  task automatic t_freeze();
    scan_in = 1'b1; cmp_force_val = 4'b1111;
    pulse();
    pulse();
    via_lvl = 4'b0000; cmp_force_val = 4'b0000; #1;
    chk("R4 source unchanged", core_data, 4'b0000);
    cmp_force_val = 4'b1111; #1;
    chk("R4 repaired lanes follow", core_data, 4'b0101);
    op_mode = 1'b0; #1;
    chk("R4 cfg frozen", core_data, 4'b0101);
    cmp_force = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select();
    t_shift();
    t_probe();
    t_recover();
    t_freeze();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule